// File: doc/BRIEF.md
# Slot-Addressed Control Decoder with Register Bank

This block serves one module in a crate. The crate backplane carries a 16-bit address bus and a 16-bit data bus. Each access is qualified by a slot match on the upper address field. The block then splits the low address byte into two 4-bit fields, a section (upper nibble) and a subsection (lower nibble). From these it produces registered one-cycle strobes:

- a write strobe for each DAC channel in seven four-channel groups;
- a module-reset strobe;
- a test-pulse strobe.

The 12-bit DAC code travels with the DAC strobe.

Six 16-bit control registers live at low bytes 0xE0 to 0xE5 and drive the module's analog controls. Most of their bits are held levels. The heat-pulse field, bits 7..4 of the register at 0xE0, is instead a pulse that lasts one clock after the write. A fixed identification word can be read at low byte 0x00. All outputs are active high.

Top module: `bpl_slot_ctrl`

## Requirements
- R1: An access whose address bits 12..8 differ from `slot_id` has no effect: no strobe, no register change, and `rd_data` stays 0.
- R2: A write to low byte 0x0F (section 0, subsection F) raises `mod_reset` for exactly the one cycle after the write edge.
- R3: That reset write clears every held register bit to 0 at the same edge, and the identification word is unchanged.
- R4: A write to low byte 0xFF raises `test_pulse` for exactly the one cycle after the write edge.
- R5: A write to section s in 1..5 with subsection 0xA..0xD raises `dac_wr_stb` bit (s-1)*4+(sub-0xA) for one cycle. In the same cycle `dac_code` shows write data bits 11..0, and it holds that value until the next DAC write.
- R6: Sections 6 and 7 use subsections 0x0..0x3 instead, with strobe bit (s-1)*4+sub. Their other subsections, and subsections 0x0..0x3 of sections 1..5, raise no strobe.
- R7: A write to 0xE0+i (i in 0..5) stores the data into register i. The value appears on `csr_out[16*i+15:16*i]` the cycle after the write and is held there.
- R8: Bits 7..4 of register 0 are pulse bits. Each written 1 shows on `csr_out` for one cycle only, and these bits read back as 0.
- R9: A read of low byte 0x00 returns {type[3:0], version[3:0], serial[7:0]} in bits 15..12, 11..8 and 7..0, which is 0xC35A by default.
- R10: Read data appears on `rd_data` the cycle after `bus_rd` is sampled, and is 0 in any cycle not preceded by a read. A read of 0xE0+i returns the held bits of register i.
- R11: Sections 8..D, low bytes 0xE6..0xEF and all other undefined addresses are ignored on write and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_id | input | 5 | This module's slot number |
| bus_addr | input | 16 | Backplane address |
| bus_wdata | input | 16 | Backplane write data |
| bus_wr | input | 1 | Write qualifier, sampled each edge |
| bus_rd | input | 1 | Read qualifier, sampled each edge |
| dac_wr_stb | output | 28 | One-cycle DAC channel write strobes, group-major |
| dac_code | output | 12 | DAC code accompanying the strobe |
| mod_reset | output | 1 | One-cycle module reset strobe |
| test_pulse | output | 1 | One-cycle test pulse strobe |
| csr_out | output | 96 | Six register outputs, register i at bits 16*i+15..16*i |
| rd_data | output | 16 | Registered read data |

## Verification
A decode fault shows up one cycle after the offending write, as a strobe on the wrong bit, a missing strobe, or a stray reset or test pulse. Because the bench drives every low byte, it catches each of these. A held register that loses or gains a bit shows on `csr_out` one cycle after the write, and again on every later read. A pulse bit that fails to clear differs on the second cycle. An error in the slot comparison shows as activity during a sweep addressed to a foreign slot.

// File: rtl/bpl_pkg.sv
package bpl_pkg;
  localparam int SEC_W = 4;
  localparam int SUB_W = 4;
  localparam int GRP_W = 3;
  localparam int CH_W  = 2;
  localparam int IDX_W = 3;

  typedef struct packed {
    logic             rst_stb;
    logic             tst_stb;
    logic             id_sel;
    logic             csr_sel;
    logic [IDX_W-1:0] csr_idx;
    logic             dac_sel;
    logic [GRP_W-1:0] grp;
    logic [CH_W-1:0]  ch;
  } bpl_dec_t;
endpackage

// File: rtl/bpl_rst_sync.sv
module bpl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb sync_nxt = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/bpl_addr_dec.sv
module bpl_addr_dec
  import bpl_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int SLOT_W        = 5,
  parameter int N_DAC_GRP     = 7,
  parameter int N_CH          = 4,
  parameter int N_CSR         = 6,
  parameter int LOW_SUB_GRP   = 6,
  parameter int HIGH_SUB_BASE = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SLOT_W-1:0] slot,
  output bpl_dec_t          dec
);
  localparam int SLOT_LSB = SEC_W + SUB_W;
  localparam logic [SEC_W-1:0] SEC_CSR  = '1 - SEC_W'(1);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(N_DAC_GRP);
  localparam logic [SEC_W-1:0] SEC_LOW  = SEC_W'(LOW_SUB_GRP);
  localparam logic [SUB_W-1:0] SUB_HIGH = SUB_W'(HIGH_SUB_BASE);
  localparam logic [SUB_W-1:0] CH_LIM   = SUB_W'(N_CH);
  localparam logic [SUB_W-1:0] CSR_LIM  = SUB_W'(N_CSR);

  logic [SEC_W-1:0] sec;
  logic [SUB_W-1:0] sub;
  logic [SUB_W-1:0] base;
  logic [SUB_W-1:0] off;
  logic             hit;

  assign sec  = addr[SUB_W +: SEC_W];
  assign sub  = addr[0 +: SUB_W];
  assign hit  = (addr[SLOT_LSB +: SLOT_W] == slot);
  assign base = (sec >= SEC_LOW) ? '0 : SUB_HIGH;
  assign off  = sub - base;

  always_comb begin
    dec = '0;
    if (hit) begin
      dec.rst_stb = (sec == '0) && (sub == '1);
      dec.id_sel  = (sec == '0) && (sub == '0);
      dec.tst_stb = (sec == '1) && (sub == '1);
      if ((sec == SEC_CSR) && (sub < CSR_LIM)) begin
        dec.csr_sel = 1'b1;
        dec.csr_idx = IDX_W'(sub);
      end
      if ((sec != '0) && (sec <= SEC_LAST) && (off < CH_LIM)) begin
        dec.dac_sel = 1'b1;
        dec.grp     = GRP_W'(sec - SEC_W'(1));
        dec.ch      = CH_W'(off);
      end
    end
  end
endmodule

// File: rtl/bpl_strobe_gen.sv
module bpl_strobe_gen
  import bpl_pkg::*;
#(
  parameter int N_DAC_GRP = 7,
  parameter int N_CH      = 4,
  parameter int CODE_W    = 12,
  parameter int DATA_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  bpl_dec_t                  dec,
  input  logic [DATA_W-1:0]         wdata,
  output logic [N_DAC_GRP*N_CH-1:0] dac_stb,
  output logic [CODE_W-1:0]         dac_code,
  output logic                      mod_rst,
  output logic                      tst
);
  localparam int N_STB = N_DAC_GRP * N_CH;

  logic [N_STB-1:0]  stb_nxt;
  logic [CODE_W-1:0] code_nxt;
  logic              code_en;
  logic              rst_nxt;
  logic              tst_nxt;

  for (genvar g = 0; g < N_DAC_GRP; g++) begin : g_grp
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      assign stb_nxt[g*N_CH + c] = wr_en && dec.dac_sel &&
                                   (dec.grp == GRP_W'(g)) && (dec.ch == CH_W'(c));
    end
  end

  always_comb begin
    code_en  = wr_en && dec.dac_sel;
    code_nxt = code_en ? wdata[CODE_W-1:0] : dac_code;
    rst_nxt  = wr_en && dec.rst_stb;
    tst_nxt  = wr_en && dec.tst_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_stb  <= '0;
      dac_code <= '0;
      mod_rst  <= 1'b0;
      tst      <= 1'b0;
    end else begin
      dac_stb  <= stb_nxt;
      dac_code <= code_nxt;
      mod_rst  <= rst_nxt;
      tst      <= tst_nxt;
    end
  end
endmodule

// File: rtl/bpl_csr_bank.sv
module bpl_csr_bank
  import bpl_pkg::*;
#(
  parameter int N_CSR  = 6,
  parameter int DATA_W = 16,
  parameter logic [N_CSR*DATA_W-1:0] PULSE_MASK = (N_CSR*DATA_W)'(16'h00F0)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        idx,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    clr,
  output logic [N_CSR*DATA_W-1:0] csr_flat,
  output logic [N_CSR*DATA_W-1:0] rd_flat
);
  for (genvar i = 0; i < N_CSR; i++) begin : g_csr
    localparam logic [DATA_W-1:0] PM = PULSE_MASK[i*DATA_W +: DATA_W];

    logic              wsel;
    logic [DATA_W-1:0] lat_q;
    logic [DATA_W-1:0] lat_nxt;
    logic [DATA_W-1:0] pls_q;
    logic [DATA_W-1:0] pls_nxt;

    always_comb begin
      wsel = wr_en && (idx == IDX_W'(i));
      if (clr)       lat_nxt = '0;
      else if (wsel) lat_nxt = wdata & ~PM;
      else           lat_nxt = lat_q;
      pls_nxt = wsel ? (wdata & PM) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat_q <= '0;
        pls_q <= '0;
      end else begin
        lat_q <= lat_nxt;
        pls_q <= pls_nxt;
      end
    end

    assign csr_flat[i*DATA_W +: DATA_W] = lat_q | pls_q;
    assign rd_flat[i*DATA_W +: DATA_W]  = lat_q;
  end
endmodule

// File: rtl/bpl_slot_ctrl.sv
module bpl_slot_ctrl
  import bpl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int SLOT_W    = 5,
  parameter int N_DAC_GRP = 7,
  parameter int N_CH      = 4,
  parameter int CODE_W    = 12,
  parameter int N_CSR     = 6,
  parameter logic [7:0] ID_SERIAL = 8'h5A,
  parameter logic [3:0] ID_REV    = 4'h3,
  parameter logic [3:0] ID_KIND   = 4'hC
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SLOT_W-1:0]           slot_id,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  output logic [N_DAC_GRP*N_CH-1:0]   dac_wr_stb,
  output logic [CODE_W-1:0]           dac_code,
  output logic                        mod_reset,
  output logic                        test_pulse,
  output logic [N_CSR*DATA_W-1:0]     csr_out,
  output logic [DATA_W-1:0]           rd_data
);
  localparam logic [DATA_W-1:0] ID_WORD = DATA_W'({ID_KIND, ID_REV, ID_SERIAL});

  logic                    rst_n_s;
  bpl_dec_t                dec;
  logic [N_CSR*DATA_W-1:0] csr_rd;
  logic [DATA_W-1:0]       rd_nxt;
  logic                    csr_wr;
  logic                    csr_clr;

  bpl_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  bpl_addr_dec #(
    .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .N_DAC_GRP(N_DAC_GRP),
    .N_CH(N_CH), .N_CSR(N_CSR), .LOW_SUB_GRP(6), .HIGH_SUB_BASE(10)
  ) dec_i (
    .addr(bus_addr), .slot(slot_id), .dec(dec)
  );

  bpl_strobe_gen #(
    .N_DAC_GRP(N_DAC_GRP), .N_CH(N_CH), .CODE_W(CODE_W), .DATA_W(DATA_W)
  ) stb_i (
    .clk(clk), .rst_n(rst_n_s), .wr_en(bus_wr), .dec(dec), .wdata(bus_wdata),
    .dac_stb(dac_wr_stb), .dac_code(dac_code), .mod_rst(mod_reset), .tst(test_pulse)
  );

  assign csr_wr  = bus_wr && dec.csr_sel;
  assign csr_clr = bus_wr && dec.rst_stb;

  bpl_csr_bank #(.N_CSR(N_CSR), .DATA_W(DATA_W)) csr_i (
    .clk(clk), .rst_n(rst_n_s), .wr_en(csr_wr), .idx(dec.csr_idx),
    .wdata(bus_wdata), .clr(csr_clr), .csr_flat(csr_out), .rd_flat(csr_rd)
  );

  always_comb begin
    rd_nxt = '0;
    if (bus_rd) begin
      if (dec.id_sel)       rd_nxt = ID_WORD;
      else if (dec.csr_sel) rd_nxt = csr_rd[int'(dec.csr_idx)*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rd_data <= '0;
    else          rd_data <= rd_nxt;
  end
endmodule

// File: rtl/bpl_slot_ctrl_chk.sv
module bpl_slot_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  slot_id,
  input logic [15:0] bus_addr,
  input logic [15:0] bus_wdata,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [27:0] dac_wr_stb,
  input logic [11:0] dac_code,
  input logic        mod_reset,
  input logic        test_pulse,
  input logic [95:0] csr_out,
  input logic [15:0] rd_data
);
  localparam logic [95:0] PLS_MASK = 96'h00F0;
  localparam logic [95:0] LAT_MASK = ~PLS_MASK;

  // R1
  slot_miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[12:8] != slot_id) |=> (dac_wr_stb == '0 && !mod_reset && !test_pulse));

  // R2
  reset_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_reset |-> $past(bus_wr && bus_addr[7:0] == 8'h0F));

  // R3
  reset_clears_csr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_reset |-> ((csr_out & LAT_MASK) == '0));

  // R4
  test_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_pulse |-> $past(bus_wr && bus_addr[7:0] == 8'hFF && bus_addr[12:8] == slot_id));

  // R5
  dac_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dac_wr_stb));

  // R5
  dac_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_wr_stb == '0) |-> $stable(dac_code));

  // R8
  pulse_bits_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((csr_out & PLS_MASK) != '0) |-> $past(bus_wr && bus_addr[7:0] == 8'hE0));

  // R10
  rd_data_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data != '0) |-> $past(bus_rd));
endmodule

bind bpl_slot_ctrl bpl_slot_ctrl_chk chk_i (.*);

// File: tb/bpl_slot_ctrl_tb_top.sv
module bpl_slot_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] MY_SLOT = 5'd9;
  localparam logic [4:0] OTHER_SLOT = 5'd10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  slot_id;
  logic [15:0] bus_addr, bus_wdata;
  logic        bus_wr, bus_rd;
  logic [27:0] dac_wr_stb;
  logic [11:0] dac_code;
  logic        mod_reset, test_pulse;
  logic [95:0] csr_out;
  logic [15:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] m_lat [6];
  logic [11:0] m_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  bpl_slot_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .slot_id(slot_id), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .dac_wr_stb(dac_wr_stb), .dac_code(dac_code), .mod_reset(mod_reset),
    .test_pulse(test_pulse), .csr_out(csr_out), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [95:0] got, input logic [95:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [27:0] exp_stb(input logic [7:0] lb);
    int sec = int'(lb[7:4]);
    int sub = int'(lb[3:0]);
    logic [27:0] r = '0;
    if (sec >= 1 && sec <= 5 && sub >= 10 && sub <= 13) r[(sec-1)*4 + sub - 10] = 1'b1;
    if ((sec == 6 || sec == 7) && sub <= 3) r[(sec-1)*4 + sub] = 1'b1;
    return r;
  endfunction

  function automatic logic [95:0] lat_flat();
    logic [95:0] f;
    for (int i = 0; i < 6; i++) f[i*16 +: 16] = m_lat[i];
    return f;
  endfunction

  task automatic wr_cyc(input logic [4:0] slot, input logic [7:0] lb, input logic [15:0] d);
    logic        hitv = (slot == MY_SLOT);
    logic [27:0] e_stb = hitv ? exp_stb(lb) : '0;
    logic [95:0] e_csr;
    string       tag;
    @(negedge clk);
    bus_addr = {3'b101, slot, lb}; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (e_stb != '0) m_code = d[11:0];
    if (hitv && lb >= 8'hE0 && lb <= 8'hE5)
      m_lat[int'(lb[2:0])] = d & ((lb == 8'hE0) ? 16'hFF0F : 16'hFFFF);
    if (hitv && lb == 8'h0F) for (int i = 0; i < 6; i++) m_lat[i] = '0;
    e_csr = lat_flat() | ((hitv && lb == 8'hE0) ? 96'(d & 16'h00F0) : '0);
    tag = !hitv ? "R1" : (lb[7:4] >= 4'h6 && lb[7:4] <= 4'h7) ? "R6" :
          (lb[7:4] >= 4'h8 && lb[7:4] <= 4'hD) ? "R11" : "R5";
    check(tag, 96'(dac_wr_stb), 96'(e_stb));
    check(hitv ? "R5" : "R1", 96'(dac_code), 96'(m_code));
    check(hitv ? "R2" : "R1", 96'(mod_reset), 96'(hitv && lb == 8'h0F));
    check(hitv ? "R4" : "R1", 96'(test_pulse), 96'(hitv && lb == 8'hFF));
    tag = !hitv ? "R1" : (lb == 8'h0F) ? "R3" : (lb == 8'hE0) ? "R8" :
          (lb >= 8'hE6 && lb <= 8'hEF) ? "R11" : "R7";
    check(tag, csr_out, e_csr);
    @(negedge clk);
    check("R8", csr_out, lat_flat());
    check("R5", 96'(dac_wr_stb), '0);
    check("R2", 96'({mod_reset, test_pulse}), '0);
  endtask

  task automatic rd_cyc(input logic [4:0] slot, input logic [7:0] lb);
    logic [15:0] e = '0;
    string tag = "R11";
    @(negedge clk);
    bus_addr = {3'b010, slot, lb}; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    if (slot != MY_SLOT) tag = "R1";
    else if (lb == 8'h00) begin e = 16'hC35A; tag = "R9"; end
    else if (lb >= 8'hE0 && lb <= 8'hE5) begin e = m_lat[int'(lb[2:0])]; tag = "R10"; end
    check(tag, 96'(rd_data), 96'(e));
    @(negedge clk);
    check("R10", 96'(rd_data), '0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; slot_id = MY_SLOT; bus_addr = '0; bus_wdata = '0;
    bus_wr = 1'b0; bus_rd = 1'b0; m_code = '0;
    for (int i = 0; i < 6; i++) m_lat[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R3", csr_out, '0);
    check("R5", 96'({dac_wr_stb, dac_code, mod_reset, test_pulse}), '0);
    check("R10", 96'(rd_data), '0);

    for (int a = 0; a < 256; a++) wr_cyc(MY_SLOT, 8'(a), {8'(a) ^ 8'h3C, ~8'(a)});
    for (int a = 0; a < 256; a++) rd_cyc(MY_SLOT, 8'(a));
    for (int a = 0; a < 256; a++) wr_cyc(OTHER_SLOT, 8'(a), 16'hA5A5);
    for (int a = 0; a < 256; a++) rd_cyc(OTHER_SLOT, 8'(a));

    for (int i = 0; i < 6; i++) wr_cyc(MY_SLOT, 8'hE0 + 8'(i), 16'hFFFF);
    for (int i = 0; i < 6; i++) rd_cyc(MY_SLOT, 8'hE0 + 8'(i));
    wr_cyc(MY_SLOT, 8'h0F, 16'h0000);
    for (int i = 0; i < 6; i++) rd_cyc(MY_SLOT, 8'hE0 + 8'(i));
    rd_cyc(MY_SLOT, 8'h00);
    finish_run();
  end
endmodule